// File: doc/BRIEF.md
# Single-Accumulator Multicycle Processor Core

This block is a small sequential processor built around one accumulator register. It steps through instructions one at a time in a fixed series of states: address out, wait for the word, decode, access the operand, write back. Each state takes one clock cycle. Program and data share one word-addressed memory port. The memory answers a read strobe with data one cycle later. A separate device port moves words between the accumulator and numbered peripherals.

The block holds a program counter, an instruction register, the accumulator and five condition flags. An integration wraps it with a synchronous memory and a set of devices. The start address comes from the `RESET_VEC` parameter. The program runs until it executes a halt, and the core then stays idle until the next reset.

Top module: `acc_cpu_core`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, the core drives `mem_rd`=1 with `mem_addr`=`RESET_VEC`. In that cycle `cc_flags` is 0 and `halted` is 0. The accumulator is reset to 0, so an output instruction executed first sends 0.
- R2: Fetch drives `mem_addr` with the PC and raises `mem_rd` for one cycle. The returned word is taken one cycle later as the instruction, and the PC advances by one.
- R3: An instruction word holds the opcode in bits [31:25] and the operand (an address, a device number or a target) in bits [24:0]. The opcodes are: load 1000000, add 1000001, subtract 1000010, jump-if-greater-or-equal 1000011, input 1000100, jump 1000101, output 1000110, store 1000111, halt 1111111.
- R4: Load copies memory[operand] into the accumulator. Store writes the accumulator to memory[operand] through `mem_wr`/`mem_wdata`.
- R5: Add and subtract write acc+mem[operand] or acc−mem[operand] to the accumulator. They also set the flags `cc_flags` = {negative[4], positive[3], zero[2], carry[1], overflow[0]}. Carry is the carry-out for add and the unsigned borrow for subtract. Overflow is signed overflow. At most one of negative, positive and zero is set.
- R6: Only add and subtract change the flags. Load, input, store, output, branches and no-ops leave them unchanged.
- R7: The greater-or-equal branch loads the operand into the PC when the positive or zero flag is set. Otherwise execution continues at the next word.
- R8: Jump loads the operand into the PC unconditionally, and the skipped words are never fetched.
- R9: Input raises `io_rd` for one cycle with `io_dev` = operand and takes `io_din` into the accumulator one cycle later. Output raises `io_wr` for one cycle with `io_dev` = operand and `io_dout` = accumulator.
- R10: After halt, `halted` stays 1 until reset, and no strobe (`mem_rd`, `mem_wr`, `io_rd`, `io_wr`) is raised.
- R11: Any opcode not listed in R3 is a no-op: it makes no access beyond its own fetch.
- R12: Load, add, subtract and input take 5 cycles. Store and output take 4. Branch, jump and no-op take 3. Halt reaches the halted state after 3.
- R13: At most one of `mem_rd`, `mem_wr`, `io_rd`, `io_wr` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_addr | output | 25 | Word address for fetch or operand access |
| mem_rd | output | 1 | Memory read strobe, data expected next cycle |
| mem_wr | output | 1 | Memory write strobe |
| mem_wdata | output | 32 | Write data (accumulator) |
| mem_rdata | input | 32 | Read data, valid the cycle after `mem_rd` |
| io_dev | output | 25 | Device number for port access |
| io_rd | output | 1 | Device read strobe, data expected next cycle |
| io_wr | output | 1 | Device write strobe |
| io_dout | output | 32 | Data to device (accumulator) |
| io_din | input | 32 | Data from device |
| cc_flags | output | 5 | Condition flags {N,P,Z,C,V} |
| halted | output | 1 | Core stopped by halt |

## Verification
A corrupted state register or opcode decode shows at the ports within one instruction. It appears as a strobe in the wrong cycle, an extra or missing read in the per-program access count, or a shifted cycle total before `halted` rises. A wrong flag or branch decision diverts the program. The wrong path then writes a different value to the output device and to memory several instructions later. Flag errors that do not change control flow are still exposed, because the flags are sampled at every output strobe.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;

    localparam int WORD_W = 32;
    localparam int OPC_W  = 7;
    localparam int OPD_W  = WORD_W - OPC_W;

    localparam logic [OPC_W-1:0] OPC_LOAD  = 7'b1000000;
    localparam logic [OPC_W-1:0] OPC_ADD   = 7'b1000001;
    localparam logic [OPC_W-1:0] OPC_SUB   = 7'b1000010;
    localparam logic [OPC_W-1:0] OPC_JGE   = 7'b1000011;
    localparam logic [OPC_W-1:0] OPC_IN    = 7'b1000100;
    localparam logic [OPC_W-1:0] OPC_JUMP  = 7'b1000101;
    localparam logic [OPC_W-1:0] OPC_OUT   = 7'b1000110;
    localparam logic [OPC_W-1:0] OPC_STORE = 7'b1000111;
    localparam logic [OPC_W-1:0] OPC_HALT  = 7'b1111111;

    typedef enum logic [2:0] {
        ST_FETCH_ADDR,
        ST_FETCH_WAIT,
        ST_DECODE,
        ST_EXEC_MEM,
        ST_WRITEBACK,
        ST_HALTED
    } cpu_state_e;

    typedef enum logic [3:0] {
        OP_LOAD, OP_ADD, OP_SUB, OP_JGE, OP_INPUT,
        OP_JUMP, OP_OUTPUT, OP_STORE, OP_HALT, OP_NOP
    } op_kind_e;

    typedef struct packed {
        logic [OPC_W-1:0] opc;
        logic [OPD_W-1:0] opd;
    } instr_t;

    // bit 4..0 : negative, positive, zero, carry/borrow, overflow
    typedef struct packed {
        logic neg;
        logic pos;
        logic zero;
        logic carry;
        logic ovf;
    } cc_flags_t;

    function automatic op_kind_e decode_op(input logic [OPC_W-1:0] opc);
        case (opc)
            OPC_LOAD:  return OP_LOAD;
            OPC_ADD:   return OP_ADD;
            OPC_SUB:   return OP_SUB;
            OPC_JGE:   return OP_JGE;
            OPC_IN:    return OP_INPUT;
            OPC_JUMP:  return OP_JUMP;
            OPC_OUT:   return OP_OUTPUT;
            OPC_STORE: return OP_STORE;
            OPC_HALT:  return OP_HALT;
            default:   return OP_NOP;
        endcase
    endfunction

endpackage

// File: rtl/acc_cpu_alu.sv
module acc_cpu_alu
    import acc_cpu_pkg::*;
(
    input  logic [WORD_W-1:0] opa,
    input  logic [WORD_W-1:0] opb,
    input  logic              do_sub,
    output logic [WORD_W-1:0] res,
    output cc_flags_t         flags
);
    logic [WORD_W:0] wide;

    always_comb begin
        if (do_sub) begin
            wide = {1'b0, opa} - {1'b0, opb};
        end else begin
            wide = {1'b0, opa} + {1'b0, opb};
        end
        res         = wide[WORD_W-1:0];
        flags.carry = wide[WORD_W];
        flags.neg   = res[WORD_W-1];
        flags.zero  = (res == '0);
        flags.pos   = !res[WORD_W-1] && (res != '0);
        if (do_sub) begin
            flags.ovf = (opa[WORD_W-1] != opb[WORD_W-1]) && (res[WORD_W-1] != opa[WORD_W-1]);
        end else begin
            flags.ovf = (opa[WORD_W-1] == opb[WORD_W-1]) && (res[WORD_W-1] != opa[WORD_W-1]);
        end
    end
endmodule

// File: rtl/acc_cpu_ctrl.sv
module acc_cpu_ctrl
    import acc_cpu_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  op_kind_e   op,
    input  logic       br_cond,
    output cpu_state_e state,
    output logic       fetch_rd,
    output logic       ir_ld,
    output logic       pc_jump,
    output logic       data_rd,
    output logic       data_wr,
    output logic       dev_rd,
    output logic       dev_wr,
    output logic       acc_ld,
    output logic       cc_ld,
    output logic       halted
);
    cpu_state_e state_nx;

    always_comb begin
        state_nx = state;
        case (state)
            ST_FETCH_ADDR: state_nx = ST_FETCH_WAIT;
            ST_FETCH_WAIT: state_nx = ST_DECODE;
            ST_DECODE: begin
                case (op)
                    OP_HALT:                   state_nx = ST_HALTED;
                    OP_JGE, OP_JUMP, OP_NOP:   state_nx = ST_FETCH_ADDR;
                    default:                   state_nx = ST_EXEC_MEM;
                endcase
            end
            ST_EXEC_MEM: begin
                if (op == OP_STORE || op == OP_OUTPUT) state_nx = ST_FETCH_ADDR;
                else                                   state_nx = ST_WRITEBACK;
            end
            ST_WRITEBACK:  state_nx = ST_FETCH_ADDR;
            default:       state_nx = ST_HALTED;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_FETCH_ADDR;
        else     state <= state_nx;
    end

    always_comb begin
        fetch_rd = (state == ST_FETCH_ADDR);
        ir_ld    = (state == ST_FETCH_WAIT);
        pc_jump  = (state == ST_DECODE) &&
                   ((op == OP_JUMP) || (op == OP_JGE && br_cond));
        data_rd  = (state == ST_EXEC_MEM) &&
                   (op == OP_LOAD || op == OP_ADD || op == OP_SUB);
        data_wr  = (state == ST_EXEC_MEM) && (op == OP_STORE);
        dev_rd   = (state == ST_EXEC_MEM) && (op == OP_INPUT);
        dev_wr   = (state == ST_EXEC_MEM) && (op == OP_OUTPUT);
        acc_ld   = (state == ST_WRITEBACK);
        cc_ld    = (state == ST_WRITEBACK) && (op == OP_ADD || op == OP_SUB);
        halted   = (state == ST_HALTED);
    end

    AST_HALT_STICKY: assert property (@(posedge clk) disable iff (rst)
        (state == ST_HALTED) |=> (state == ST_HALTED)); // R10
    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (rst)
        $onehot0({fetch_rd, data_rd, data_wr, dev_rd, dev_wr})); // R13
    AST_FETCH_WAIT: assert property (@(posedge clk) disable iff (rst)
        (state == ST_FETCH_ADDR) |=> (state == ST_FETCH_WAIT)); // R12
    AST_WB_AFTER_EXEC: assert property (@(posedge clk) disable iff (rst)
        (state == ST_WRITEBACK) |-> ($past(state) == ST_EXEC_MEM)); // R12
endmodule

// File: rtl/acc_cpu_core.sv
module acc_cpu_core
    import acc_cpu_pkg::*;
#(
    parameter logic [OPD_W-1:0] RESET_VEC = '0
)(
    input  logic              clk,
    input  logic              rst,
    output logic [OPD_W-1:0]  mem_addr,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic [OPD_W-1:0]  io_dev,
    output logic              io_rd,
    output logic              io_wr,
    output logic [WORD_W-1:0] io_dout,
    input  logic [WORD_W-1:0] io_din,
    output logic [4:0]        cc_flags,
    output logic              halted
);
    logic [OPD_W-1:0]  pc;
    instr_t            ir;
    logic [WORD_W-1:0] acc;
    cc_flags_t         flags;

    op_kind_e   op;
    cpu_state_e state;
    logic fetch_rd, ir_ld, pc_jump, data_rd, data_wr, dev_rd, dev_wr, acc_ld, cc_ld;
    logic [WORD_W-1:0] alu_res;
    cc_flags_t         alu_flags;
    logic [WORD_W-1:0] wb_val;

    assign op = decode_op(ir.opc);

    acc_cpu_ctrl u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .op       (op),
        .br_cond  (flags.pos | flags.zero),
        .state    (state),
        .fetch_rd (fetch_rd),
        .ir_ld    (ir_ld),
        .pc_jump  (pc_jump),
        .data_rd  (data_rd),
        .data_wr  (data_wr),
        .dev_rd   (dev_rd),
        .dev_wr   (dev_wr),
        .acc_ld   (acc_ld),
        .cc_ld    (cc_ld),
        .halted   (halted)
    );

    acc_cpu_alu u_alu (
        .opa    (acc),
        .opb    (mem_rdata),
        .do_sub (op == OP_SUB),
        .res    (alu_res),
        .flags  (alu_flags)
    );

    always_comb begin
        case (op)
            OP_INPUT: wb_val = io_din;
            OP_LOAD:  wb_val = mem_rdata;
            default:  wb_val = alu_res;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pc    <= RESET_VEC;
            ir    <= '0;
            acc   <= '0;
            flags <= '0;
        end else begin
            if (ir_ld) begin
                ir <= instr_t'(mem_rdata);
                pc <= pc + OPD_W'(1);
            end
            if (pc_jump) pc    <= ir.opd;
            if (acc_ld)  acc   <= wb_val;
            if (cc_ld)   flags <= alu_flags;
        end
    end

    assign mem_addr  = fetch_rd ? pc : ir.opd;
    assign mem_rd    = fetch_rd | data_rd;
    assign mem_wr    = data_wr;
    assign mem_wdata = acc;
    assign io_dev    = ir.opd;
    assign io_rd     = dev_rd;
    assign io_wr     = dev_wr;
    assign io_dout   = acc;
    assign cc_flags  = flags;

    AST_PC_STEP: assert property (@(posedge clk) disable iff (rst)
        (state == ST_FETCH_WAIT) |=> (pc == $past(pc) + OPD_W'(1))); // R2
    AST_RESET_VEC: assert property (@(posedge clk)
        rst |=> (pc == RESET_VEC && acc == '0 && flags == '0)); // R1
    AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (rst)
        (state != ST_WRITEBACK) |=> $stable(flags)); // R6
    AST_SIGN_EXCL: assert property (@(posedge clk) disable iff (rst)
        $onehot0({flags.neg, flags.pos, flags.zero})); // R5
    AST_JUMP_TARGET: assert property (@(posedge clk) disable iff (rst)
        (state == ST_DECODE && op == OP_JUMP) |=> (pc == $past(ir.opd))); // R8
    AST_HALT_QUIET: assert property (@(posedge clk) disable iff (rst)
        halted |-> !(mem_rd || mem_wr || io_rd || io_wr)); // R10
endmodule

// File: tb/acc_cpu_core_tb.sv
module acc_cpu_core_tb;
    import acc_cpu_pkg::*;

    logic              clk = 0;
    logic              rst = 1;
    logic [OPD_W-1:0]  mem_addr;
    logic              mem_rd, mem_wr, io_rd, io_wr, halted;
    logic [WORD_W-1:0] mem_wdata, io_dout;
    logic [WORD_W-1:0] mem_rdata = '0;
    logic [WORD_W-1:0] io_din = '0;
    logic [OPD_W-1:0]  io_dev;
    logic [4:0]        cc_flags;

    always #5 clk = ~clk;

    acc_cpu_core #(.RESET_VEC(25'd4)) u_dut (
        .clk(clk), .rst(rst), .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .io_dev(io_dev), .io_rd(io_rd),
        .io_wr(io_wr), .io_dout(io_dout), .io_din(io_din), .cc_flags(cc_flags),
        .halted(halted)
    );

    int checks = 0;
    int errors = 0;

    logic [WORD_W-1:0] mem [64];
    logic              ld_en = 0;
    logic [5:0]        ld_addr = '0;
    logic [WORD_W-1:0] ld_data = '0;
    logic [WORD_W-1:0] in_a = '0, in_b = '0;
    int in_idx, ocnt, rd_cnt, ovl_cnt, bad_dev, cyc;
    logic [WORD_W-1:0] obuf_val [4];
    logic [OPD_W-1:0]  obuf_dev [4];
    logic [4:0]        obuf_flg [4];

    always @(posedge clk) begin
        if (ld_en) mem[ld_addr] <= ld_data;
        else if (mem_wr) mem[mem_addr[5:0]] <= mem_wdata;
        if (mem_rd) mem_rdata <= mem[mem_addr[5:0]];
    end

    always @(posedge clk) begin
        if (rst) begin
            in_idx <= 0; ocnt <= 0; rd_cnt <= 0; ovl_cnt <= 0; bad_dev <= 0; cyc <= 0;
        end else begin
            if (io_rd) begin
                io_din <= (in_idx == 0) ? in_a : in_b;
                in_idx <= in_idx + 1;
                if (io_dev != 25'd33) bad_dev <= bad_dev + 1;
            end
            if (io_wr) begin
                if (ocnt < 4) begin
                    obuf_val[ocnt] <= io_dout;
                    obuf_dev[ocnt] <= io_dev;
                    obuf_flg[ocnt] <= cc_flags;
                end
                ocnt <= ocnt + 1;
            end
            if (mem_rd) rd_cnt <= rd_cnt + 1;
            if ($countones({mem_rd, mem_wr, io_rd, io_wr}) > 1) ovl_cnt <= ovl_cnt + 1;
            if (!halted) cyc <= cyc + 1;
        end
    end

    function automatic logic [31:0] enc(logic [6:0] opc, int opd);
        return {opc, 25'(opd)};
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic put(int a, logic [31:0] d);
        @(negedge clk);
        ld_en = 1; ld_addr = 6'(a); ld_data = d;
    endtask

    task automatic enter_reset();
        @(negedge clk);
        ld_en = 0; rst = 1;
        @(negedge clk);
    endtask

    task automatic release_reset();
        @(negedge clk);
        ld_en = 0;
        @(negedge clk);
        rst = 0;
    endtask

    task automatic wait_halt(string req);
        int n = 0;
        while (!halted && n < 400) begin
            @(negedge clk);
            n++;
        end
        chk(req, 32'(halted), 32'd1);
    endtask

    localparam logic [63:0] VEC [6] = '{
        64'h00000003_00000005,
        64'h00000009_00000004,
        64'h00000007_00000007,
        64'h7FFFFFFF_FFFFFFFF,
        64'h80000000_00000001,
        64'h00000000_FFFFFFFF
    };

    initial begin : watchdog
        #1000000;
        errors++;
        checks++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        // Table walk: compare/branch program over (a,b) pairs  (R2 R3 R4 R5 R7 R8 R9)
        for (int v = 0; v < 6; v++) begin
            logic [31:0] a, b, diff, exp;
            a = VEC[v][63:32];
            b = VEC[v][31:0];
            diff = a - b;
            exp  = diff[31] ? (a + b) : diff;
            enter_reset();
            in_a = a; in_b = b;
            put(4,  enc(OPC_IN, 33));    put(5,  enc(OPC_STORE, 40));
            put(6,  enc(OPC_IN, 33));    put(7,  enc(OPC_STORE, 41));
            put(8,  enc(OPC_LOAD, 40));  put(9,  enc(OPC_SUB, 41));
            put(10, enc(OPC_JGE, 15));   put(11, enc(OPC_LOAD, 40));
            put(12, enc(OPC_ADD, 41));   put(13, enc(OPC_STORE, 42));
            put(14, enc(OPC_JUMP, 18));  put(15, enc(OPC_LOAD, 40));
            put(16, enc(OPC_SUB, 41));   put(17, enc(OPC_STORE, 42));
            put(18, enc(OPC_LOAD, 42));  put(19, enc(OPC_OUT, 2049));
            put(20, enc(OPC_HALT, 0));
            release_reset();
            wait_halt("R10 table halt");
            chk("R9 R7 output value", obuf_val[0], exp);
            chk("R9 output device", 32'(obuf_dev[0]), 32'd2049);
            chk("R9 single output", 32'(ocnt), 32'd1);
            chk("R4 stored result", mem[42], exp);
            chk("R9 input device number", 32'(bad_dev), 32'd0);
            chk("R13 strobe overlap", 32'(ovl_cnt), 32'd0);
        end

        // Flags, load keeps flags, no-op, jump skip, borrow
        enter_reset();
        put(4, enc(OPC_LOAD, 40));  put(5, enc(OPC_ADD, 41));
        put(6, {7'b0000000, 25'd40});
        put(7, enc(OPC_LOAD, 42));  put(8, enc(OPC_OUT, 7));
        put(9, enc(OPC_JUMP, 12));  put(10, enc(OPC_OUT, 9));
        put(11, enc(OPC_HALT, 0));  put(12, enc(OPC_SUB, 43));
        put(13, enc(OPC_OUT, 5));   put(14, enc(OPC_HALT, 0));
        put(40, 32'hFFFFFFFF); put(41, 32'h1); put(42, 32'h12345678); put(43, 32'h12345679);
        release_reset();
        wait_halt("R10 flag program halt");
        chk("R6 load keeps flags (add carry+zero)", 32'(obuf_flg[0]), 32'b00110);
        chk("R4 load value", obuf_val[0], 32'h12345678);
        chk("R8 jump skips output", 32'(ocnt), 32'd2);
        chk("R8 second output device", 32'(obuf_dev[1]), 32'd5);
        chk("R5 subtract result", obuf_val[1], 32'hFFFFFFFF);
        chk("R5 borrow and negative", 32'(obuf_flg[1]), 32'b10010);
        chk("R11 no-op access count", 32'(rd_cnt), 32'd13);

        // Signed overflow, cycle count, halt sticky
        enter_reset();
        put(4, enc(OPC_LOAD, 40)); put(5, enc(OPC_SUB, 41));
        put(6, enc(OPC_OUT, 3));   put(7, enc(OPC_HALT, 0));
        put(40, 32'h80000000); put(41, 32'h1);
        release_reset();
        wait_halt("R10 overflow program halt");
        chk("R5 overflow result", obuf_val[0], 32'h7FFFFFFF);
        chk("R5 overflow flags", 32'(obuf_flg[0]), 32'b01001);
        chk("R12 cycles to halt", 32'(cyc), 32'd17);
        repeat (20) @(negedge clk);
        chk("R10 no reads after halt", 32'(rd_cnt), 32'd6);
        chk("R10 halted sticky", 32'(halted), 32'd1);

        // Reset state and cleared accumulator
        enter_reset();
        put(4, enc(OPC_OUT, 1)); put(5, enc(OPC_HALT, 0));
        release_reset();
        #1;
        chk("R1 read strobe at reset", 32'(mem_rd), 32'd1);
        chk("R1 reset vector address", 32'(mem_addr), 32'd4);
        chk("R1 flags cleared", 32'(cc_flags), 32'd0);
        chk("R1 not halted", 32'(halted), 32'd0);
        wait_halt("R10 reset program halt");
        chk("R1 accumulator cleared", obuf_val[0], 32'd0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule